// File: doc/BRIEF.md
# Edge Event Latch with Interrupt

This block watches eight debounced digital inputs and records, per channel, a sticky event flag when the channel sees the transition selected by its polarity bit. A channel can be armed or disarmed. Writing 0 to its event bit clears the flag and disarms the channel. Writing 1 arms it again, and only then can it latch a new event. The latched flags are combined into a single active-low interrupt request. That request is gated by two enable bits and by the enhanced-mode input.

Software reaches the block through a small write/read register port with an address, write data and a write strobe. The read data is combinational. The data address is banked. In bank 0 it returns the live input levels. In bank 1 it returns the event flags and accepts writes to the arm/clear bits. A synchronous software reset returns everything to its idle state except the master interrupt bit. That bit survives a software reset and is cleared only by the power-up reset.

Top module: `edge_event_irq`

## Requirements
- R1: Polarity register (address 1) bit i = 1 makes channel i detect a low-to-high transition. Bit i = 0 makes it detect high-to-low. The opposite transition never sets the flag.
- R2: A set event flag stays set, whatever the input does, until it is cleared by a write or a reset.
- R3: In bank 1, a write to address 0 with bit i = 0 clears flag i and disarms channel i. A disarmed channel ignores edges. A later write with bit i = 1 re-arms it.
- R4: The interrupt output irqN (active low) is asserted only when some flag is set, interrupt enable (address 3, bit 0) is 1, master interrupt (address 4, bit 0) is 1, and enhancedMode is 1.
- R5: irqN stays asserted until every set flag has been cleared.
- R6: Clearing master interrupt bit 0 deasserts irqN while flags remain set.
- R7: swReset clears flags, arm bits, polarity, bank select and interrupt enable, and leaves master interrupt unchanged. rstN clears all of them, including master interrupt.
- R8: Bank select is address 2, bit 0. A read of address 0 returns din in bank 0 and the flags in bank 1. A write to address 0 in bank 0 has no effect on the flags.
- R9: irqN is registered. It changes one clock after the flag or enable change that causes it.
- R10: With enhancedMode = 0, irqN stays deasserted (high) even when flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| swReset | input | 1 | Synchronous software reset pulse |
| enhancedMode | input | 1 | Enables interrupt generation when high |
| din | input | 8 | Debounced channel inputs |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Combinational read data for addr |
| irqN | output | 1 | Registered interrupt request, active low |

## Verification
The edge detector is driven with single rising steps on rising-polarity channels and with full pulses on falling-polarity channels. These patterns separate a correct polarity decode from a detector that fires on any change. The same input toggles are then repeated on a disarmed channel and again after re-arming, which exposes a clear that does not disarm. Two flags are set at once and then removed one at a time. This shows whether the interrupt follows the OR of all flags or only the last event. Each enable is dropped in turn with flags still set: the master bit, the mode input, a software reset and a power-up reset. Each drop checks the gating and which bits each reset keeps.

// File: rtl/edge_event_pkg.sv
`timescale 1ns/1ps
package edge_event_pkg;
  localparam int ADDR_DATA   = 0;
  localparam int ADDR_POL    = 1;
  localparam int ADDR_BANK   = 2;
  localparam int ADDR_IER    = 3;
  localparam int ADDR_MASTER = 4;

  typedef struct packed {
    logic armWr;    // write to arm/clear bits (bank 1, data address)
    logic swReset;  // synchronous software reset
    logic irqGate;  // all interrupt enables satisfied
  } ctrlStrobe_t;
endpackage

// File: rtl/event_ctrl.sv
`timescale 1ns/1ps
module event_ctrl
  import edge_event_pkg::*;
#(
  parameter int NumCh = 8,
  parameter int AddrW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             enhancedMode,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [NumCh-1:0] wrData,
  input  logic [NumCh-1:0] din,
  input  logic [NumCh-1:0] flags,
  output ctrlStrobe_t      strb,
  output logic [NumCh-1:0] polarity,
  output logic [NumCh-1:0] rdData
);
  logic bankSel;
  logic ierBit;
  logic masterBit;

  logic wrPol, wrBank, wrIer, wrMaster;
  assign wrPol    = wrEn && (addr == AddrW'(ADDR_POL));
  assign wrBank   = wrEn && (addr == AddrW'(ADDR_BANK));
  assign wrIer    = wrEn && (addr == AddrW'(ADDR_IER));
  assign wrMaster = wrEn && (addr == AddrW'(ADDR_MASTER));

  // Registers cleared by both resets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polarity <= '0;
      bankSel  <= 1'b0;
      ierBit   <= 1'b0;
    end else if (swReset) begin
      polarity <= '0;
      bankSel  <= 1'b0;
      ierBit   <= 1'b0;
    end else begin
      if (wrPol)  polarity <= wrData;
      if (wrBank) bankSel  <= wrData[0];
      if (wrIer)  ierBit   <= wrData[0];
    end
  end

  // Master bit: only the power-up reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         masterBit <= 1'b0;
    else if (wrMaster) masterBit <= wrData[0];
  end

  always_comb begin
    strb.armWr   = wrEn && !swReset && bankSel && (addr == AddrW'(ADDR_DATA));
    strb.swReset = swReset;
    strb.irqGate = ierBit && masterBit && enhancedMode;
  end

  always_comb begin
    case (addr)
      AddrW'(ADDR_DATA):   rdData = bankSel ? flags : din;
      AddrW'(ADDR_POL):    rdData = polarity;
      AddrW'(ADDR_BANK):   rdData = NumCh'(bankSel);
      AddrW'(ADDR_IER):    rdData = NumCh'(ierBit);
      AddrW'(ADDR_MASTER): rdData = NumCh'(masterBit);
      default:             rdData = '0;
    endcase
  end

  // R7: software reset keeps the master bit
  a_r7_master_kept: assert property (@(posedge clk) disable iff (!rstN)
    (swReset && !wrMaster) |=> (masterBit == $past(masterBit)));
  // R7: software reset clears interrupt enable
  a_r7_ier_cleared: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> !ierBit);
  // R8: no arm/clear strobe while bank 0 is selected
  a_r8_bank0_no_arm: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |-> !strb.armWr);
endmodule

// File: rtl/event_datapath.sv
`timescale 1ns/1ps
module event_datapath
  import edge_event_pkg::*;
#(
  parameter int NumCh = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [NumCh-1:0] polarity,
  input  logic [NumCh-1:0] wrData,
  input  logic [NumCh-1:0] din,
  output logic [NumCh-1:0] flags,
  output logic             irqN
);
  logic [NumCh-1:0] dinQ;
  logic [NumCh-1:0] armed;
  logic [NumCh-1:0] edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dinQ <= '0;
    else       dinQ <= din;
  end

  for (genvar i = 0; i < NumCh; i++) begin : g_ch
    assign edgeHit[i] = polarity[i] ? (din[i] & ~dinQ[i]) : (~din[i] & dinQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed[i] <= 1'b0;
        flags[i] <= 1'b0;
      end else if (strb.swReset) begin
        armed[i] <= 1'b0;
        flags[i] <= 1'b0;
      end else if (strb.armWr) begin
        armed[i] <= wrData[i];
        flags[i] <= wrData[i] & (flags[i] | (armed[i] & edgeHit[i]));
      end else if (armed[i] && edgeHit[i]) begin
        flags[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~((|flags) & strb.irqGate);
  end

  // R2: flags are sticky without a write or reset
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.armWr && !strb.swReset) |=> ((flags & $past(flags)) == $past(flags)));
  // R3: a disarmed channel never gains a flag
  a_r3_disarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~$past(armed) & flags & ~$past(flags)) == '0));
  // R4/R9: enabled and flagged leads to request next cycle
  a_r4_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    ((|flags) && strb.irqGate) |=> !irqN);
  // R6/R10: gate off means request released next cycle
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.irqGate |=> irqN);
  // R5: no flags means no request next cycle
  a_r5_all_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0) |=> irqN);
endmodule

// File: rtl/edge_event_irq.sv
`timescale 1ns/1ps
module edge_event_irq
  import edge_event_pkg::*;
#(
  parameter int NumCh = 8,
  parameter int AddrW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             enhancedMode,
  input  logic [NumCh-1:0] din,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [NumCh-1:0] wrData,
  output logic [NumCh-1:0] rdData,
  output logic             irqN
);
  ctrlStrobe_t      strb;
  logic [NumCh-1:0] polarity;
  logic [NumCh-1:0] flags;

  event_ctrl #(.NumCh(NumCh), .AddrW(AddrW)) u_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .enhancedMode(enhancedMode),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .din(din), .flags(flags),
    .strb(strb), .polarity(polarity), .rdData(rdData)
  );

  event_datapath #(.NumCh(NumCh)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .polarity(polarity),
    .wrData(wrData), .din(din), .flags(flags), .irqN(irqN)
  );
endmodule

// File: tb/tb_edge_event_irq.sv
`timescale 1ns/1ps
module tb_edge_event_irq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic       enhancedMode = 1'b0;
  logic [7:0] din = '0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqN;

  edge_event_irq dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int         dueQ[$];
  bit         kindQ[$];  // 0: rdData, 1: irqN
  logic [7:0] expQ[$];
  string      tagQ[$];

  always @(negedge clk) begin
    while (dueQ.size() > 0 && dueQ[0] == cyc) begin
      logic [7:0] act;
      act = kindQ[0] ? {7'd0, irqN} : rdData;
      checks++;
      if (act !== expQ[0]) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", tagQ[0], act, expQ[0]);
      end
      void'(dueQ.pop_front()); void'(kindQ.pop_front());
      void'(expQ.pop_front()); void'(tagQ.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic expRd(input logic [2:0] a, input logic [7:0] e, input string tag);
    addr = a;
    dueQ.push_back(cyc); kindQ.push_back(1'b0); expQ.push_back(e); tagQ.push_back(tag);
    step();
  endtask

  task automatic expIrq(input logic e, input string tag);
    dueQ.push_back(cyc); kindQ.push_back(1'b1); expQ.push_back({7'd0, e}); tagQ.push_back(tag);
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    din = 8'h5A;
    #20; rstN = 1'b1;
    step();
    // reset state (R7, R8)
    expIrq(1'b1, "R7 reset irqN");
    expRd(3'd0, 8'h5A, "R8 bank0 reads din");
    expRd(3'd3, 8'h00, "R7 reset ier");
    expRd(3'd4, 8'h00, "R7 reset master");
    din = 8'h00; step();

    enhancedMode = 1'b1;
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h0F);       // ch0-3 rising, ch4-7 falling
    wr(3'd2, 8'h01);       // bank 1
    wr(3'd0, 8'hFF);       // arm all
    expRd(3'd0, 8'h00, "R3 armed no flags");

    // R1 rising on ch0, R9 latency
    din = 8'h01; step();
    expIrq(1'b1, "R9 irq one cycle later");
    step();
    expIrq(1'b0, "R4 irq asserted");
    expRd(3'd0, 8'h01, "R1 rising flag ch0");
    // R2 sticky
    din = 8'h00; step();
    expRd(3'd0, 8'h01, "R2 flag sticky");

    // R1 rising edge on falling channel ch4 then its fall
    din = 8'h10; step();
    expRd(3'd0, 8'h01, "R1 rising ignored on ch4");
    din = 8'h00; step();
    expRd(3'd0, 8'h11, "R1 falling flag ch4");

    // R8 bank0 write ignored
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h01);
    expRd(3'd0, 8'h11, "R8 bank0 write ignored");

    // R6 master off
    wr(3'd4, 8'h00);
    step();
    expIrq(1'b1, "R6 master clear releases irq");
    expRd(3'd0, 8'h11, "R6 flags kept");
    wr(3'd4, 8'h01);
    step();
    expIrq(1'b0, "R4 master restored");

    // R10 standard mode
    enhancedMode = 1'b0; step(); step();
    expIrq(1'b1, "R10 standard mode no irq");
    enhancedMode = 1'b1; step(); step();
    expIrq(1'b0, "R10 enhanced again");

    // R5 / R3 clear one flag at a time
    wr(3'd0, 8'hFE);       // clear+disarm ch0
    expIrq(1'b0, "R9 irq held one cycle");
    step();
    expIrq(1'b0, "R5 irq held with ch4 set");
    expRd(3'd0, 8'h10, "R3 clear ch0");
    din = 8'h01; step(); din = 8'h00; step(); din = 8'h01; step();
    expRd(3'd0, 8'h10, "R3 disarmed ch0 ignores edge");
    wr(3'd0, 8'hEF);       // clear ch4, ch0 re-armed
    step();
    expIrq(1'b1, "R5 irq released all clear");
    din = 8'h00; step(); din = 8'h01; step();
    expRd(3'd0, 8'h01, "R3 re-armed ch0 fires");
    step();
    expIrq(1'b0, "R4 irq after rearm");

    // R7 software reset
    swReset = 1'b1; step(); swReset = 1'b0; step();
    expIrq(1'b1, "R7 swReset irq off");
    expRd(3'd4, 8'h01, "R7 swReset keeps master");
    expRd(3'd3, 8'h00, "R7 swReset clears ier");
    expRd(3'd1, 8'h00, "R7 swReset clears polarity");
    expRd(3'd2, 8'h00, "R7 swReset clears bank");
    wr(3'd2, 8'h01);
    expRd(3'd0, 8'h00, "R7 swReset clears flags");

    // R7 power-up reset
    rstN = 1'b0; #3; rstN = 1'b1; step();
    expRd(3'd4, 8'h00, "R7 rstN clears master");
    expIrq(1'b1, "R7 rstN irq off");
    step(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule